// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block keeps one page request entry for each of several acquisition circuits and checks every incoming teletext page header against all of them in parallel. An entry names a magazine, page tens and units, and a four-digit time subcode (hours tens and units, minutes tens and units). Each digit carries its own do-care flag, and the entry also has a hold flag. When a header arrives as Hamming-decoded nibbles with a per-byte error flag, every circuit whose entry accepts the header raises a one-cycle capture strobe. The circuit also records the header, so that it can present the received-page control bytes of display row 25.

Entries are loaded through a narrow configuration path. A load strobe selects a circuit and a start column. Each write strobe then stores one 5-bit column and moves the column pointer to the next column. Each circuit keeps a page-being-looked-for flag and an active-low found flag. A read port returns any row-25 control byte of any circuit. Hamming decoding and the writes into page memory are done by neighbouring blocks.

Top module: `page_req_matcher`

## Requirements
- R1: After reset, every entry is all zeros, so every circuit is held and never captures. Every circuit reads row-25 column 9 as 0x10 (found flag high, looked-for flag low) and columns 0 to 8 as 0x00. No capture strobe is active.
- R2: A load strobe sets the pointer to circuit `cfg_circ` and column `cfg_col`. Each write strobe stores `cfg_data` at the pointed column and advances the column by one, wrapping from 6 to 0 within the same circuit. A load and a write in the same cycle write at the newly loaded address.
- R3: A start column of 7 is treated as column 0.
- R4: The entry columns are 0 = {care, HOLD, magazine[2:0]}, 1 = page tens, 2 = page units, 3 = hours tens (2 bits), 4 = hours units, 5 = minutes tens (3 bits), 6 = minutes units. Bit 4 of each column is the do-care flag and the value sits in the low bits. A digit whose do-care bit is 0 is ignored. A digit whose do-care bit is 1 must equal the header digit.
- R5: A cared digit whose header byte carries a Hamming error prevents a match. An error on an ignored digit has no effect. Error flags are indexed by row-25 column: 0 PU, 1 PT, 2 MU, 3 MT, 4 HU, 5 HT, 8 MAG.
- R6: When the HOLD bit (column 0, bit 3) is 0, the circuit does not capture even if the header matches.
- R7: A header presented with `hdr_valid` in cycle N raises `cap_strobe[i]` for exactly one cycle, in cycle N+1, for every accepting circuit. Several circuits may capture the same header.
- R8: A capture makes the circuit's found flag 0 and clears its looked-for flag. Row-25 column 9 holds the found flag in bit 4 and the looked-for flag in bit 5, with every other bit 0.
- R9: A write to any column of an entry sets that circuit's looked-for flag and its found flag to 1.
- R10: A circuit whose entry is written in the same cycle as a header does not capture that header.
- R11: Row-25 bytes from the last captured header carry the Hamming error of that byte in bit 4, with bits 7..5 zero. The bytes by column are: 0 = PU; 1 = PT; 2 = MU; 3 = {C4, MT[2:0]}; 4 = HU; 5 = {C6, C5, HT[1:0]}; 6 = C10..C7; 7 = C14..C11; 8 = {0, MAG}. Columns 10 to 15 read 0. `hdr_ctl` bit k holds control bit C(4+k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load pointer with circuit and start column |
| cfg_circ | input | 3 | Circuit selected by a load |
| cfg_col | input | 3 | Start column selected by a load |
| cfg_wr | input | 1 | Write one entry column at the pointer |
| cfg_data | input | 5 | Column data: do-care bit 4, value bits 3..0 |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_mag | input | 3 | Magazine |
| hdr_pt | input | 4 | Page tens |
| hdr_pu | input | 4 | Page units |
| hdr_ht | input | 2 | Hours tens |
| hdr_hu | input | 4 | Hours units |
| hdr_mt | input | 3 | Minutes tens |
| hdr_mu | input | 4 | Minutes units |
| hdr_ctl | input | 11 | Control bits C4..C14 (bit 0 = C4) |
| hdr_err | input | 9 | Hamming error per row-25 column 0..8 |
| rd_circ | input | 3 | Circuit for row-25 read |
| rd_col | input | 4 | Row-25 column to read |
| rd_byte | output | 8 | Row-25 control byte |
| cap_strobe | output | 8 | One-cycle capture strobe per circuit |

## Verification
The bench aims at pointer wrap from column 6 to 0, a start column of 7, and a load combined with a write. A design that got these wrong would place data in the wrong column and then match headers it should reject. It sends headers whose Hamming errors sit on cared and on ignored digits, headers that match a held entry, and writes that collide with a header for the same circuit. A wrong design would capture corrupt or held pages, or would clear the looked-for flag for a request that has just been changed. Constrained random headers built near the programmed entries exercise partial and multiple matches. After every header the bench compares the found and looked-for flags and the row-25 byte layout.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  localparam int COLS  = 7;
  localparam int COL_W = 5;

  typedef struct packed {
    logic [2:0]  mag;
    logic [3:0]  pt;
    logic [3:0]  pu;
    logic [1:0]  ht;
    logic [3:0]  hu;
    logic [2:0]  mt;
    logic [3:0]  mu;
    logic [10:0] ctl;
    logic [8:0]  err;
  } hdr_t;

  // A digit passes when it is not cared about, or equal and error free
  function automatic logic digit_ok(input logic care, input logic eq, input logic err);
    return !care || (eq && !err);
  endfunction

  function automatic logic [7:0] row25_byte(input hdr_t h, input logic [3:0] col,
                                             input logic found_n, input logic pbl);
    logic [7:0] b;
    b = 8'h00;
    case (col)
      4'd0: b = {3'b000, h.err[0], h.pu};
      4'd1: b = {3'b000, h.err[1], h.pt};
      4'd2: b = {3'b000, h.err[2], h.mu};
      4'd3: b = {3'b000, h.err[3], h.ctl[0], h.mt};
      4'd4: b = {3'b000, h.err[4], h.hu};
      4'd5: b = {3'b000, h.err[5], h.ctl[2], h.ctl[1], h.ht};
      4'd6: b = {3'b000, h.err[6], h.ctl[6:3]};
      4'd7: b = {3'b000, h.err[7], h.ctl[10:7]};
      4'd8: b = {3'b000, h.err[8], 1'b0, h.mag};
      4'd9: b = {2'b00, pbl, found_n, 4'b0000};
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pgm_req_store.sv
module pgm_req_store #(
  parameter int NC = 8,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             cfg_load,
  input  logic [CW-1:0]                                    cfg_circ,
  input  logic [2:0]                                       cfg_col,
  input  logic                                             cfg_wr,
  input  logic [pgm_pkg::COL_W-1:0]                        cfg_data,
  output logic [NC-1:0][pgm_pkg::COLS-1:0][pgm_pkg::COL_W-1:0] ent,
  output logic [NC-1:0]                                    wr_hit,
  output logic [2:0]                                       ptr_col
);
  import pgm_pkg::*;

  localparam logic [2:0] LAST_COL = 3'(COLS - 1);

  logic [CW-1:0] ptr_circ_q, ptr_circ_d;
  logic [2:0]    ptr_col_q, ptr_col_d;
  logic [CW-1:0] eff_circ;
  logic [2:0]    eff_col, load_col;
  logic [NC-1:0][COLS-1:0][COL_W-1:0] ent_q, ent_d;

  always_comb begin
    load_col = (cfg_col > LAST_COL) ? 3'd0 : cfg_col;
    eff_circ = cfg_load ? cfg_circ : ptr_circ_q;
    eff_col  = cfg_load ? load_col : ptr_col_q;
  end

  always_comb begin
    ptr_circ_d = ptr_circ_q;
    ptr_col_d  = ptr_col_q;
    if (cfg_wr) begin
      ptr_circ_d = eff_circ;
      ptr_col_d  = (eff_col == LAST_COL) ? 3'd0 : eff_col + 3'd1;
    end else if (cfg_load) begin
      ptr_circ_d = cfg_circ;
      ptr_col_d  = load_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_circ_q <= '0;
      ptr_col_q  <= '0;
    end else begin
      ptr_circ_q <= ptr_circ_d;
      ptr_col_q  <= ptr_col_d;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_circ
    assign wr_hit[i] = cfg_wr && (eff_circ == CW'(i));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_comb begin
        ent_d[i][c] = ent_q[i][c];
        if (wr_hit[i] && (eff_col == 3'(c)))
          ent_d[i][c] = cfg_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q[i][c] <= '0;
        else        ent_q[i][c] <= ent_d[i][c];
      end
    end
  end

  assign ent     = ent_q;
  assign ptr_col = ptr_col_q;

endmodule

// File: rtl/pgm_hdr_compare.sv
module pgm_hdr_compare #(
  parameter int NC = 8
) (
  input  logic                                                 hdr_valid,
  input  pgm_pkg::hdr_t                                        hdr,
  input  logic [NC-1:0][pgm_pkg::COLS-1:0][pgm_pkg::COL_W-1:0] ent,
  input  logic [NC-1:0]                                        wr_hit,
  output logic [NC-1:0]                                        hit,
  output logic [NC-1:0]                                        hold_ok
);
  import pgm_pkg::*;

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    logic [COLS-1:0] dig_ok;
    always_comb begin
      dig_ok[0] = digit_ok(ent[i][0][4], ent[i][0][2:0] == hdr.mag, hdr.err[8]);
      dig_ok[1] = digit_ok(ent[i][1][4], ent[i][1][3:0] == hdr.pt,  hdr.err[1]);
      dig_ok[2] = digit_ok(ent[i][2][4], ent[i][2][3:0] == hdr.pu,  hdr.err[0]);
      dig_ok[3] = digit_ok(ent[i][3][4], ent[i][3][1:0] == hdr.ht,  hdr.err[5]);
      dig_ok[4] = digit_ok(ent[i][4][4], ent[i][4][3:0] == hdr.hu,  hdr.err[4]);
      dig_ok[5] = digit_ok(ent[i][5][4], ent[i][5][2:0] == hdr.mt,  hdr.err[3]);
      dig_ok[6] = digit_ok(ent[i][6][4], ent[i][6][3:0] == hdr.mu,  hdr.err[2]);
    end
    assign hold_ok[i] = ent[i][0][3];
    assign hit[i]     = hdr_valid && (&dig_ok) && hold_ok[i] && !wr_hit[i];
  end

endmodule

// File: rtl/pgm_cap_record.sv
module pgm_cap_record #(
  parameter int NC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pgm_pkg::hdr_t         hdr,
  input  logic [NC-1:0]         hit,
  input  logic [NC-1:0]         wr_hit,
  output pgm_pkg::hdr_t [NC-1:0] cap_hdr,
  output logic [NC-1:0]         found_n,
  output logic [NC-1:0]         pbl,
  output logic [NC-1:0]         strobe
);
  import pgm_pkg::*;

  for (genvar i = 0; i < NC; i++) begin : g_rec
    hdr_t hdr_q, hdr_d;
    logic fnd_q, fnd_d, pbl_q, pbl_d, stb_q, stb_d;

    always_comb begin
      hdr_d = hdr_q;
      fnd_d = fnd_q;
      pbl_d = pbl_q;
      stb_d = hit[i];
      if (hit[i]) begin
        hdr_d = hdr;
        fnd_d = 1'b0;
        pbl_d = 1'b0;
      end else if (wr_hit[i]) begin
        fnd_d = 1'b1;
        pbl_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hdr_q <= '0;
        fnd_q <= 1'b1;
        pbl_q <= 1'b0;
        stb_q <= 1'b0;
      end else begin
        hdr_q <= hdr_d;
        fnd_q <= fnd_d;
        pbl_q <= pbl_d;
        stb_q <= stb_d;
      end
    end

    assign cap_hdr[i] = hdr_q;
    assign found_n[i] = fnd_q;
    assign pbl[i]     = pbl_q;
    assign strobe[i]  = stb_q;
  end

endmodule

// File: rtl/page_req_matcher.sv
module page_req_matcher #(
  parameter int NC = 8,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_circ,
  input  logic [2:0]    cfg_col,
  input  logic          cfg_wr,
  input  logic [4:0]    cfg_data,
  input  logic          hdr_valid,
  input  logic [2:0]    hdr_mag,
  input  logic [3:0]    hdr_pt,
  input  logic [3:0]    hdr_pu,
  input  logic [1:0]    hdr_ht,
  input  logic [3:0]    hdr_hu,
  input  logic [2:0]    hdr_mt,
  input  logic [3:0]    hdr_mu,
  input  logic [10:0]   hdr_ctl,
  input  logic [8:0]    hdr_err,
  input  logic [CW-1:0] rd_circ,
  input  logic [3:0]    rd_col,
  output logic [7:0]    rd_byte,
  output logic [NC-1:0] cap_strobe
);
  import pgm_pkg::*;

  logic [NC-1:0][COLS-1:0][COL_W-1:0] ent;
  logic [NC-1:0] wr_hit, hit, hold_ok, found_n, pbl;
  logic [2:0]    ptr_col;
  hdr_t          hdr;
  hdr_t [NC-1:0] cap_hdr;

  assign hdr = '{mag: hdr_mag, pt: hdr_pt, pu: hdr_pu, ht: hdr_ht, hu: hdr_hu,
                 mt: hdr_mt, mu: hdr_mu, ctl: hdr_ctl, err: hdr_err};

  pgm_req_store #(.NC(NC)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_circ(cfg_circ),
    .cfg_col(cfg_col), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .ent(ent), .wr_hit(wr_hit), .ptr_col(ptr_col)
  );

  pgm_hdr_compare #(.NC(NC)) u_cmp (
    .hdr_valid(hdr_valid), .hdr(hdr), .ent(ent), .wr_hit(wr_hit),
    .hit(hit), .hold_ok(hold_ok)
  );

  pgm_cap_record #(.NC(NC)) u_rec (
    .clk(clk), .rst_n(rst_n), .hdr(hdr), .hit(hit), .wr_hit(wr_hit),
    .cap_hdr(cap_hdr), .found_n(found_n), .pbl(pbl), .strobe(cap_strobe)
  );

  always_comb begin
    rd_byte = 8'h00;
    if (int'(rd_circ) < NC)
      rd_byte = row25_byte(cap_hdr[rd_circ], rd_col, found_n[rd_circ], pbl[rd_circ]);
  end

endmodule

// File: rtl/pgm_checker.sv
module pgm_checker #(
  parameter int NC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hdr_valid,
  input logic [NC-1:0] cap_strobe,
  input logic [NC-1:0] found_n,
  input logic [NC-1:0] pbl,
  input logic [NC-1:0] hold_ok,
  input logic [NC-1:0] wr_hit,
  input logic [2:0]    ptr_col
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_strobe_after_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (|cap_strobe)) |-> $past(hdr_valid));

  assert_ptr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_col <= 3'd6);

  for (genvar i = 0; i < NC; i++) begin : g_chk
    assert_cap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe[i] |-> (!found_n[i] && !pbl[i]));
    assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (started && cap_strobe[i]) |-> $past(hold_ok[i]));
    assert_write_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_hit[i])) |-> (found_n[i] && pbl[i] && !cap_strobe[i]));
  end
endmodule

bind page_req_matcher pgm_checker #(.NC(NC)) u_pgm_checker (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .cap_strobe(cap_strobe),
  .found_n(found_n), .pbl(pbl), .hold_ok(hold_ok), .wr_hit(wr_hit), .ptr_col(ptr_col)
);

// File: tb/tb_page_req_matcher.sv
module tb_page_req_matcher;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_load = 0, cfg_wr = 0, hdr_valid = 0;
  logic [2:0]  cfg_circ = 0, cfg_col = 0;
  logic [4:0]  cfg_data = 0;
  logic [2:0]  hdr_mag = 0, hdr_mt = 0;
  logic [3:0]  hdr_pt = 0, hdr_pu = 0, hdr_hu = 0, hdr_mu = 0;
  logic [1:0]  hdr_ht = 0;
  logic [10:0] hdr_ctl = 0;
  logic [8:0]  hdr_err = 0;
  logic [2:0]  rd_circ = 0;
  logic [3:0]  rd_col = 0;
  logic [7:0]  rd_byte;
  logic [NC-1:0] cap_strobe;

  page_req_matcher #(.NC(NC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_circ(cfg_circ), .cfg_col(cfg_col),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .hdr_valid(hdr_valid), .hdr_mag(hdr_mag),
    .hdr_pt(hdr_pt), .hdr_pu(hdr_pu), .hdr_ht(hdr_ht), .hdr_hu(hdr_hu), .hdr_mt(hdr_mt),
    .hdr_mu(hdr_mu), .hdr_ctl(hdr_ctl), .hdr_err(hdr_err), .rd_circ(rd_circ),
    .rd_col(rd_col), .rd_byte(rd_byte), .cap_strobe(cap_strobe)
  );

  typedef struct packed {
    bit [2:0] mag; bit [3:0] pt; bit [3:0] pu; bit [1:0] ht; bit [3:0] hu;
    bit [2:0] mt; bit [3:0] mu; bit [10:0] ctl; bit [8:0] err;
  } th_t;

  int total = 0, bad = 0;
  bit done = 0;
  bit [4:0] m_ent [NC][7];
  int m_pc = 0, m_pcol = 0;
  bit m_fn [NC];
  bit m_pbl [NC];
  th_t m_cap [NC];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic th_t cur_hdr();
    th_t h;
    h.mag = hdr_mag; h.pt = hdr_pt; h.pu = hdr_pu; h.ht = hdr_ht; h.hu = hdr_hu;
    h.mt = hdr_mt; h.mu = hdr_mu; h.ctl = hdr_ctl; h.err = hdr_err;
    return h;
  endfunction

  function automatic bit dok(bit [4:0] e, int v, bit er, int w);
    if (!e[4]) return 1'b1;
    return (int'(e[3:0]) % (1 << w)) == v && !er;
  endfunction

  // R4 R5 R6: expected acceptance of header h by circuit i
  function automatic bit exp_match(int i, th_t h);
    return dok(m_ent[i][0], h.mag, h.err[8], 3) && dok(m_ent[i][1], h.pt, h.err[1], 4) &&
           dok(m_ent[i][2], h.pu, h.err[0], 4) && dok(m_ent[i][3], h.ht, h.err[5], 2) &&
           dok(m_ent[i][4], h.hu, h.err[4], 4) && dok(m_ent[i][5], h.mt, h.err[3], 3) &&
           dok(m_ent[i][6], h.mu, h.err[2], 4) && m_ent[i][0][3];
  endfunction

  // R8 R11: expected row-25 byte
  function automatic bit [7:0] exp_byte(int i, int col);
    th_t h = m_cap[i];
    case (col)
      0: return {3'b0, h.err[0], h.pu};
      1: return {3'b0, h.err[1], h.pt};
      2: return {3'b0, h.err[2], h.mu};
      3: return {3'b0, h.err[3], h.ctl[0], h.mt};
      4: return {3'b0, h.err[4], h.hu};
      5: return {3'b0, h.err[5], h.ctl[2], h.ctl[1], h.ht};
      6: return {3'b0, h.err[6], h.ctl[6:3]};
      7: return {3'b0, h.err[7], h.ctl[10:7]};
      8: return {3'b0, h.err[8], 1'b0, h.mag};
      9: return {2'b0, m_pbl[i], m_fn[i], 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  // one cycle of stimulus; header fields are taken from the globals
  task automatic step(input bit ld, input int circ, input int col, input bit wr,
                      input bit [4:0] d, input bit hv, input string req);
    int ec, ecol;
    bit [NC-1:0] eh;
    th_t h;
    @(negedge clk);
    cfg_load = ld; cfg_circ = 3'(circ); cfg_col = 3'(col); cfg_wr = wr; cfg_data = d;
    hdr_valid = hv;
    h = cur_hdr();
    ec = ld ? circ : m_pc;
    ecol = ld ? ((col > 6) ? 0 : col) : m_pcol;
    for (int i = 0; i < NC; i++)
      eh[i] = hv && exp_match(i, h) && !(wr && ec == i);
    @(negedge clk);
    cfg_load = 0; cfg_wr = 0; hdr_valid = 0;
    if (wr) begin
      m_ent[ec][ecol] = d; m_fn[ec] = 1; m_pbl[ec] = 1;
      m_pc = ec; m_pcol = (ecol == 6) ? 0 : ecol + 1;
    end else if (ld) begin
      m_pc = circ; m_pcol = (col > 6) ? 0 : col;
    end
    for (int i = 0; i < NC; i++)
      if (eh[i]) begin m_cap[i] = h; m_fn[i] = 0; m_pbl[i] = 0; end
    check({req, " strobe"}, int'(cap_strobe), int'(eh));
  endtask

  task automatic chk_row(input int i, input int col, input string req);
    rd_circ = 3'(i); rd_col = 4'(col);
    #1;
    check(req, int'(rd_byte), int'(exp_byte(i, col)));
  endtask

  task automatic set_hdr(input bit [2:0] mg, input bit [3:0] t, input bit [3:0] u,
                         input bit [1:0] a, input bit [3:0] b, input bit [2:0] c,
                         input bit [3:0] e, input bit [8:0] er);
    hdr_mag = mg; hdr_pt = t; hdr_pu = u; hdr_ht = a; hdr_hu = b; hdr_mt = c; hdr_mu = e;
    hdr_err = er;
  endtask

  task automatic load_entry(input int i, input bit [4:0] c0, input bit [4:0] c1,
                            input bit [4:0] c2, input bit [4:0] c3, input bit [4:0] c4,
                            input bit [4:0] c5, input bit [4:0] c6);
    step(1, i, 0, 1, c0, 0, "R2");
    step(0, 0, 0, 1, c1, 0, "R2");
    step(0, 0, 0, 1, c2, 0, "R2");
    step(0, 0, 0, 1, c3, 0, "R2");
    step(0, 0, 0, 1, c4, 0, "R2");
    step(0, 0, 0, 1, c5, 0, "R2");
    step(0, 0, 0, 1, c6, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NC; i++) begin
      m_fn[i] = 1; m_pbl[i] = 0; m_cap[i] = '0;
      for (int c = 0; c < 7; c++) m_ent[i][c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    check("R1 strobe", int'(cap_strobe), 0);
    for (int i = 0; i < NC; i++) begin
      chk_row(i, 9, "R1 col9");
      chk_row(i, 0, "R1 col0");
    end
    set_hdr(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, "R1 held");

    // R4 R7: circuit 1 wants magazine 3 page 45, any time
    load_entry(1, 5'h1B, 5'h14, 5'h15, 5'h00, 5'h00, 5'h00, 5'h00);
    chk_row(1, 9, "R9 col9 after write");
    set_hdr(3, 4, 5, 2, 7, 5, 9, 0);
    hdr_ctl = 11'h5A3;
    step(0, 0, 0, 0, 0, 1, "R7 match");
    for (int c = 0; c < 16; c++) chk_row(1, c, "R11 layout");
    step(0, 0, 0, 0, 0, 0, "R7 one cycle");
    set_hdr(3, 4, 6, 2, 7, 5, 9, 0);
    step(0, 0, 0, 0, 0, 1, "R4 units mismatch");
    // R5: error on cared digit vs ignored digit
    set_hdr(3, 4, 5, 2, 7, 5, 9, 9'h001);
    step(0, 0, 0, 0, 0, 1, "R5 cared error");
    set_hdr(3, 4, 5, 2, 7, 5, 9, 9'h004);
    step(0, 0, 0, 0, 0, 1, "R5 ignored error");
    chk_row(1, 2, "R11 err bit");
    // R6: hold
    step(1, 1, 0, 1, 5'h13, 0, "R6 hold write");
    set_hdr(3, 4, 5, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, "R6 held");
    chk_row(1, 9, "R6 flags");
    // R2: wrap, circuit 2 from column 5
    step(1, 2, 5, 1, 5'h12, 0, "R2 col5");
    step(0, 0, 0, 1, 5'h13, 0, "R2 col6");
    step(0, 0, 0, 1, 5'h1E, 0, "R2 wrap col0");
    step(0, 0, 0, 1, 5'h17, 0, "R2 col1");
    set_hdr(6, 7, 1, 0, 0, 2, 3, 0);
    step(0, 0, 0, 0, 0, 1, "R2 wrap match");
    // R3: start column 7 treated as 0
    step(1, 4, 7, 1, 5'h19, 0, "R3 col7");
    set_hdr(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, "R3 match mag1");
    chk_row(4, 9, "R8 col9");
    // R10: write collides with header
    set_hdr(1, 2, 2, 0, 0, 0, 0, 0);
    step(1, 4, 3, 1, 5'h00, 1, "R10 collide");
    chk_row(4, 9, "R10 flags");
    step(0, 0, 0, 0, 0, 1, "R10 next header");

    // random entries and headers
    for (int i = 0; i < NC; i++) begin
      bit [4:0] e[7];
      for (int c = 0; c < 7; c++)
        e[c] = {($urandom % 3) != 0 ? 1'b1 : 1'b0, 4'($urandom)};
      e[0][3] = ($urandom % 5) != 0;
      load_entry(i, e[0], e[1], e[2], e[3], e[4], e[5], e[6]);
    end
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom % NC);
      bit [8:0] er = 0;
      for (int b = 0; b < 9; b++) er[b] = ($urandom % 10) == 0;
      set_hdr(m_ent[k][0][2:0], m_ent[k][1][3:0], m_ent[k][2][3:0], m_ent[k][3][1:0],
              m_ent[k][4][3:0], m_ent[k][5][2:0], m_ent[k][6][3:0], er);
      if ($urandom % 3 == 0) hdr_pu = 4'($urandom);
      if ($urandom % 4 == 0) hdr_mu = 4'($urandom);
      if ($urandom % 5 == 0) hdr_mag = 3'($urandom);
      hdr_ctl = 11'($urandom);
      if ($urandom % 12 == 0)
        step(1, int'($urandom % NC), int'($urandom % 8), 1, 5'($urandom), 1, "R10 R4 rand");
      else
        step(0, 0, 0, 0, 0, 1, "R4 R5 R7 rand");
      chk_row(int'($urandom % NC), int'($urandom % 10), "R8 R11 rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule